// File: doc/BRIEF.md
# Single-Accumulator Ten-Operation Datapath

This block is a small register-transfer core built around an accumulator. It holds an accumulator, one general-purpose register and an output register. On every clock edge where the instruction-valid input is high, it decodes a 4-bit operation code and performs one of ten transfers or ALU operations. The operands come from the data input port, the accumulator or the general register. All three registers drive ports so that their contents can be observed directly.

Typical use is as the execute stage of a tiny controller, or as a target for checking a decoder and datapath. An external sequencer supplies operation codes and input data. One example sequence is: load the general register from the input, load the accumulator from the input, add, then copy the accumulator to the output. At the end of this sequence the sum sits on the output port.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the general register and the output register to zero at the next rising edge.
- R2: Code 1 and code 6 each load the accumulator from `data_in`.
- R3: Code 2 copies the accumulator into the general register.
- R4: Code 3 copies the general register into the output register, and code 4 copies the accumulator into the output register.
- R5: Code 5 loads the general register from `data_in`.
- R6: Code 7 puts accumulator plus general register into the accumulator. The sum is taken modulo 2^WIDTH and the carry is dropped.
- R7: Code 8 puts accumulator OR general register into the accumulator, and code 9 puts accumulator AND general register into the accumulator.
- R8: Code 10 replaces the accumulator with its bitwise complement.
- R9: The accumulator changes only under codes 1, 6, 7, 8, 9 and 10. The general register changes only under codes 2 and 5. The output register changes only under codes 3 and 4.
- R10: Codes 0 and 11 through 15 leave all three registers unchanged.
- R11: A cycle with `instr_valid` low leaves all three registers unchanged, whatever code is presented.
- R12: The sequence 5, 1, 7, 4 issued on consecutive valid cycles places the modulo sum of the two loaded input words on `out_q` after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Qualifies the code on `opcode` for this cycle |
| opcode | input | 4 | Operation code |
| data_in | input | WIDTH | Input data word |
| acc_q | output | WIDTH | Accumulator contents |
| gpr_q | output | WIDTH | General register contents |
| out_q | output | WIDTH | Output register contents |

## Verification
The assertions assume that `opcode`, `data_in` and `instr_valid` are known values at every clock edge after reset. They also assume that reset lasts at least one edge. The stimulus drives all inputs on the falling edge from defined values only. It holds reset for several cycles before it issues any operation. It then walks every code, both valid and invalid, with carry-producing and all-ones operands, so that the properties on holding and on the write set see every decode path.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP0  = 4'd0,
    OP_LDA   = 4'd1,
    OP_A2G   = 4'd2,
    OP_G2O   = 4'd3,
    OP_A2O   = 4'd4,
    OP_LDG   = 4'd5,
    OP_LDA2  = 4'd6,
    OP_ADD   = 4'd7,
    OP_OR    = 4'd8,
    OP_AND   = 4'd9,
    OP_INV   = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    SRC_IN  = 2'd0,
    SRC_ACC = 2'd1,
    SRC_GPR = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    FN_PASS_IN = 3'd0,
    FN_ADD     = 3'd1,
    FN_OR      = 3'd2,
    FN_AND     = 3'd3,
    FN_INV     = 3'd4
  } fn_e;

  typedef struct packed {
    logic we_acc;
    logic we_gpr;
    logic we_out;
    fn_e  acc_fn;
    src_e gpr_src;
    src_e out_src;
  } ctrl_t;
endpackage

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic           valid,
  input  logic [OPW-1:0] op,
  output ctrl_t          ctrl
);
  always_comb begin
    ctrl = '{we_acc: 1'b0, we_gpr: 1'b0, we_out: 1'b0,
             acc_fn: FN_PASS_IN, gpr_src: SRC_IN, out_src: SRC_ACC};
    if (valid) begin
      case (op)
        OP_LDA, OP_LDA2: begin ctrl.we_acc = 1'b1; ctrl.acc_fn = FN_PASS_IN; end
        OP_ADD:          begin ctrl.we_acc = 1'b1; ctrl.acc_fn = FN_ADD; end
        OP_OR:           begin ctrl.we_acc = 1'b1; ctrl.acc_fn = FN_OR; end
        OP_AND:          begin ctrl.we_acc = 1'b1; ctrl.acc_fn = FN_AND; end
        OP_INV:          begin ctrl.we_acc = 1'b1; ctrl.acc_fn = FN_INV; end
        OP_A2G:          begin ctrl.we_gpr = 1'b1; ctrl.gpr_src = SRC_ACC; end
        OP_LDG:          begin ctrl.we_gpr = 1'b1; ctrl.gpr_src = SRC_IN; end
        OP_G2O:          begin ctrl.we_out = 1'b1; ctrl.out_src = SRC_GPR; end
        OP_A2O:          begin ctrl.we_out = 1'b1; ctrl.out_src = SRC_ACC; end
        default: ;
      endcase
    end
  end

  // r9_: at most one destination register is written per cycle
  always_comb begin
    a_onehot_dest_r9: assert ($onehot0({ctrl.we_acc, ctrl.we_gpr, ctrl.we_out}));
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  fn_e              fn,
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] gpr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] res
);
  function automatic logic [WIDTH-1:0] add_wrap(input logic [WIDTH-1:0] a,
                                                input logic [WIDTH-1:0] b);
    logic [WIDTH:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[WIDTH-1:0];
  endfunction

  always_comb begin
    case (fn)
      FN_ADD:  res = add_wrap(acc, gpr);
      FN_OR:   res = acc | gpr;
      FN_AND:  res = acc & gpr;
      FN_INV:  res = ~acc;
      default: res = din;
    endcase
  end
endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] alu_res,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] acc,
  output logic [WIDTH-1:0] gpr,
  output logic [WIDTH-1:0] outr
);
  logic [WIDTH-1:0] gpr_nxt, out_nxt;

  assign gpr_nxt = (ctrl.gpr_src == SRC_ACC) ? acc : din;
  assign out_nxt = (ctrl.out_src == SRC_GPR) ? gpr : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      gpr  <= '0;
      outr <= '0;
    end else begin
      if (ctrl.we_acc) acc  <= alu_res;
      if (ctrl.we_gpr) gpr  <= gpr_nxt;
      if (ctrl.we_out) outr <= out_nxt;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (acc == '0 && gpr == '0 && outr == '0));
  p_acc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.we_acc |=> $stable(acc));
  p_gpr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.we_gpr |=> $stable(gpr));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !ctrl.we_out |=> $stable(outr));
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             instr_valid,
  input  logic [3:0]       opcode,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] gpr_q,
  output logic [WIDTH-1:0] out_q
);
  ctrl_t            ctrl;
  logic [WIDTH-1:0] alu_res;

  acc_decode u_dec (.valid(instr_valid), .op(opcode), .ctrl(ctrl));

  acc_alu #(.WIDTH(WIDTH)) u_alu (
    .fn(ctrl.acc_fn), .acc(acc_q), .gpr(gpr_q), .din(data_in), .res(alu_res));

  acc_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst), .ctrl(ctrl), .alu_res(alu_res), .din(data_in),
    .acc(acc_q), .gpr(gpr_q), .outr(out_q));

  p_invalid_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> ($stable(acc_q) && $stable(gpr_q) && $stable(out_q)));
  p_unused_code_r10: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (opcode == 4'd0 || opcode > 4'd10)) |=>
      ($stable(acc_q) && $stable(gpr_q) && $stable(out_q)));
  p_load_acc_r2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (opcode == 4'd1 || opcode == 4'd6)) |=> acc_q == $past(data_in));
  p_copy_gpr_r3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opcode == 4'd2) |=> gpr_q == $past(acc_q));
  p_out_src_r4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opcode == 4'd3) |=> out_q == $past(gpr_q));
  p_load_gpr_r5: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opcode == 4'd5) |=> gpr_q == $past(data_in));
  p_invert_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && opcode == 4'd10) |=> acc_q == ~$past(acc_q));
endmodule

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         instr_valid;
  logic [3:0]   opcode;
  logic [W-1:0] data_in;
  logic [W-1:0] acc_q, gpr_q, out_q;

  int n_cmp = 0;
  int n_bad = 0;
  int m_a, m_r, m_o;

  always #2 clk = ~clk;

  acc_core #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .opcode(opcode),
    .data_in(data_in), .acc_q(acc_q), .gpr_q(gpr_q), .out_q(out_q));

  task automatic cmp(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Reference update, written from the requirement list
  task automatic model_step(input bit v, input int op, input int d);
    int a0, r0;
    a0 = m_a; r0 = m_r;
    if (!v) return;
    if (op == 1 || op == 6) m_a = d;
    else if (op == 7)  m_a = (a0 + r0) % 256;
    else if (op == 8)  m_a = a0 | r0;
    else if (op == 9)  m_a = a0 & r0;
    else if (op == 10) m_a = 255 - a0;
    else if (op == 2)  m_r = a0;
    else if (op == 5)  m_r = d;
    else if (op == 3)  m_o = r0;
    else if (op == 4)  m_o = a0;
  endtask

  function automatic string tag_of(input bit v, input int op);
    if (!v) return "R11";
    case (op)
      1, 6: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      7: return "R6";
      8, 9: return "R7";
      10: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic issue(input bit v, input int op, input int d);
    string t;
    instr_valid = v; opcode = op[3:0]; data_in = d[W-1:0];
    @(posedge clk);
    model_step(v, op, d);
    @(negedge clk);
    t = tag_of(v, op);
    cmp({t, "/R9 acc"}, int'(acc_q), m_a);
    cmp({t, "/R9 gpr"}, int'(gpr_q), m_r);
    cmp({t, "/R9 out"}, int'(out_q), m_o);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; instr_valid = 1'b0; opcode = 4'd0; data_in = '0;
    m_a = 0; m_r = 0; m_o = 0;
    repeat (3) @(negedge clk);
    cmp("R1 acc", int'(acc_q), 0);
    cmp("R1 gpr", int'(gpr_q), 0);
    cmp("R1 out", int'(out_q), 0);
    rst = 1'b0;

    // R12 sequence: 200 + 100 wraps to 44
    issue(1, 5, 200);
    issue(1, 1, 100);
    issue(1, 7, 0);
    issue(1, 4, 0);
    cmp("R12 sum on out", int'(out_q), 44);

    // each code, plus an invalid and an unused one
    for (int op = 0; op < 16; op++) begin
      issue(1, 6, 8'hA5);
      issue(1, 5, 8'h3C);
      issue(1, op, 8'h77);
      issue(0, op, 8'h11);
    end
    issue(1, 1, 8'hFF); issue(1, 10, 0);
    cmp("R8 invert ones", int'(acc_q), 0);
    issue(1, 1, 8'h0F); issue(1, 5, 8'hF0); issue(1, 8, 0);
    cmp("R7 or", int'(acc_q), 255);
    issue(1, 9, 0); issue(1, 3, 0);
    cmp("R4 out from gpr", int'(out_q), 8'hF0);

    for (int k = 0; k < 600; k++)
      issue((k % 7) != 0, (k * 13 + 5) % 16, (k * 37 + 11) % 256);

    // R1 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    m_a = 0; m_r = 0; m_o = 0;
    cmp("R1 acc again", int'(acc_q), 0);
    cmp("R1 out again", int'(out_q), 0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule